// File: doc/BRIEF.md
# Single-Master Bus Fabric with Region Decoder and Default Responder

This block connects one bus master to several slave ports. On the address side it compares the master address against a fixed table of regions. Every region starts and ends on a 1KB boundary, and each region drives its own select line. A slave port can own more than one region. Each of its regions then acts as a separate logical window, and the slave does not have to decode the address itself. Address and control reach every slave in parallel. Only the select lines come from this block.

An address that hits no region goes to a built-in default responder. On the data side, the slave chosen in the last accepted address phase returns its read data, response, ready and exclusive-okay flag to the master. The resulting ready goes back out to every slave. The data-phase selection is captured only when ready is high, so the response stays with the same slave while that slave stretches a transfer with wait states.

Top module: `ahb_lite_fabric`

## Requirements
- R1: With default parameters the regions are [0x0000_0000, 0x0000_1000), [0x0000_4000, 0x0000_4400), [0x0001_0000, 0x0001_2000) and [0x8000_0000, 0x8000_0400). Each has a base and a size that are multiples of 1KB. `s_hsel[r]` is high exactly when `m_haddr` lies inside region r, and this includes the first and last word of the region.
- R2: Region r drives bit r of `s_hsel`. Regions 0 and 3 both belong to slave port 0, region 1 belongs to slave port 1, and region 2 belongs to slave port 2. At most one bit of `s_hsel` is high at any time.
- R3: In the data phase, `m_hrdata`, `m_hresp`, `m_hready` and `m_hexokay` equal the outputs of the slave port that owned the region hit by the previously accepted address phase. This includes an error or wait response from that slave.
- R4: The data-phase selection changes only on a clock edge where `m_hready` is high. While a slave holds its ready low, its data and response stay routed even if the master address changes.
- R5: A NONSEQ (`m_htrans`=2) or SEQ (`m_htrans`=3) transfer to an unmapped address gets a two-cycle error in the following data phase. The first cycle has `m_hresp`=1 and `m_hready`=0. The second cycle has `m_hresp`=1 and `m_hready`=1.
- R6: An IDLE (`m_htrans`=0) or BUSY (`m_htrans`=1) transfer to an unmapped address gets `m_hresp`=0 and `m_hready`=1 in the next cycle, with no wait state. Whenever the default responder is in the data phase, `m_hrdata` is 0.
- R7: `s_hready` equals `m_hready` in every cycle.
- R8: With `EXCL_EN`=1, `m_hexokay` follows the selected slave's `s_hexokay` bit. It is 0 whenever the default responder is in the data phase.
- R9: After reset the default responder holds the data phase, with `m_hready`=1, `m_hresp`=0, `m_hrdata`=0 and `m_hexokay`=0.
- R10: An address outside all regions drives every bit of `s_hsel` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_haddr | input | ADDR_W | Master address |
| m_htrans | input | 2 | Master transfer type (0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ) |
| m_hrdata | output | DATA_W | Read data to master |
| m_hresp | output | 1 | Response to master, 1 = ERROR |
| m_hready | output | 1 | Transfer-complete flag to master |
| m_hexokay | output | 1 | Exclusive-okay flag to master |
| s_hsel | output | NUM_REGIONS | One select line per region |
| s_hready | output | 1 | Ready broadcast to all slaves |
| s_hrdata | input | NUM_SLAVES*DATA_W | Read data of all slaves, slave i at bits i*DATA_W upward |
| s_hresp | input | NUM_SLAVES | Response of each slave |
| s_hreadyout | input | NUM_SLAVES | Ready output of each slave |
| s_hexokay | input | NUM_SLAVES | Exclusive-okay of each slave |

## Verification
The decoder is driven with the first and last word of every region and with the words just outside each region. This separates an off-by-one limit compare from a correct one. The shared slave port 0 is reached through both of its windows, which shows that each window has its own select line. Unmapped addresses are tried with all four transfer types, which separates the two-cycle error path from the zero-wait OKAY path. A slave that stretches a transfer while the master presents a new address shows whether the data-phase selection is captured only on ready.

// File: rtl/ahb_lite_fabric.sv
module ahb_lite_fabric #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int NUM_SLAVES  = 3,
  parameter int NUM_REGIONS = 4,
  parameter bit EXCL_EN     = 1'b1,
  parameter logic [ADDR_W-1:0] RGN_BASE [NUM_REGIONS] =
    '{32'h0000_0000, 32'h0000_4000, 32'h0001_0000, 32'h8000_0000},
  parameter logic [ADDR_W-1:0] RGN_SIZE [NUM_REGIONS] =
    '{32'h0000_1000, 32'h0000_0400, 32'h0000_2000, 32'h0000_0400},
  parameter int RGN_OWNER [NUM_REGIONS] = '{0, 1, 2, 0}
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [ADDR_W-1:0]            m_haddr,
  input  logic [1:0]                   m_htrans,
  output logic [DATA_W-1:0]            m_hrdata,
  output logic                         m_hresp,
  output logic                         m_hready,
  output logic                         m_hexokay,
  output logic [NUM_REGIONS-1:0]       s_hsel,
  output logic                         s_hready,
  input  logic [NUM_SLAVES*DATA_W-1:0] s_hrdata,
  input  logic [NUM_SLAVES-1:0]        s_hresp,
  input  logic [NUM_SLAVES-1:0]        s_hreadyout,
  input  logic [NUM_SLAVES-1:0]        s_hexokay
);

  localparam int IDX_W = $clog2(NUM_SLAVES + 1);
  localparam logic [IDX_W-1:0] DFLT_IDX = IDX_W'(NUM_SLAVES);

  typedef enum logic [1:0] {DS_OK, DS_ERR1, DS_ERR2} dflt_state_t;

  logic [IDX_W-1:0] a_idx, d_idx;
  dflt_state_t      ds_q;
  logic             d_dflt;
  logic             sel_xok;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
    assign s_hsel[r] = (m_haddr >= RGN_BASE[r]) &&
                       ({1'b0, m_haddr} < ({1'b0, RGN_BASE[r]} + {1'b0, RGN_SIZE[r]}));
  end

  always_comb begin
    a_idx = DFLT_IDX;
    for (int r = 0; r < NUM_REGIONS; r++)
      if (s_hsel[r]) a_idx = IDX_W'(RGN_OWNER[r]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        d_idx <= DFLT_IDX;
    else if (m_hready) d_idx <= a_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ds_q <= DS_OK;
    else if (ds_q == DS_ERR1) ds_q <= DS_ERR2;
    else if (m_hready)
      ds_q <= (a_idx == DFLT_IDX && m_htrans[1]) ? DS_ERR1 : DS_OK;
  end

  assign d_dflt = (d_idx == DFLT_IDX);

  always_comb begin
    m_hrdata = '0;
    m_hresp  = (ds_q != DS_OK);
    m_hready = (ds_q != DS_ERR1);
    sel_xok  = 1'b0;
    if (!d_dflt) begin
      for (int s = 0; s < NUM_SLAVES; s++) begin
        if (d_idx == IDX_W'(s)) begin
          m_hrdata = s_hrdata[s*DATA_W +: DATA_W];
          m_hresp  = s_hresp[s];
          m_hready = s_hreadyout[s];
          sel_xok  = s_hexokay[s];
        end
      end
    end
  end

  if (EXCL_EN) begin : g_xok
    assign m_hexokay = sel_xok;
  end else begin : g_no_xok
    assign m_hexokay = 1'b0;
  end

  assign s_hready = m_hready;

endmodule

// File: rtl/ahb_lite_fabric_chk.sv
module ahb_lite_fabric_chk #(
  parameter int DATA_W      = 32,
  parameter int NUM_REGIONS = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0]             m_htrans,
  input logic [DATA_W-1:0]      m_hrdata,
  input logic                   m_hresp,
  input logic                   m_hready,
  input logic                   m_hexokay,
  input logic [NUM_REGIONS-1:0] s_hsel
);

  p_sel_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(s_hsel));

  p_unmapped_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_hready && s_hsel == '0 && m_htrans[1]) |=> (m_hresp && !m_hready));

  p_err_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_hresp && !m_hready) |=> (m_hresp && m_hready));

  p_unmapped_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_hready && s_hsel == '0 && !m_htrans[1]) |=> (!m_hresp && m_hready));

  p_dflt_rdata_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_hready && s_hsel == '0) |=> (m_hrdata == '0));

  p_dflt_xok_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_hready && s_hsel == '0) |=> !m_hexokay);

  p_reset_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (m_hready && !m_hresp && m_hrdata == '0));

endmodule

bind ahb_lite_fabric ahb_lite_fabric_chk #(
  .DATA_W(DATA_W), .NUM_REGIONS(NUM_REGIONS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .m_htrans(m_htrans), .m_hrdata(m_hrdata),
  .m_hresp(m_hresp), .m_hready(m_hready), .m_hexokay(m_hexokay), .s_hsel(s_hsel)
);

// File: tb/ahb_lite_fabric_tb_top.sv
module ahb_lite_fabric_tb_top;
  localparam int NS = 3;
  localparam int NR = 4;
  localparam int DW = 32;
  localparam logic [31:0] T_BASE [NR] = '{32'h0, 32'h4000, 32'h1_0000, 32'h8000_0000};
  localparam logic [31:0] T_SIZE [NR] = '{32'h1000, 32'h400, 32'h2000, 32'h400};
  localparam int NV = 13;
  // {addr, htrans, expected select, source: 0..2 slave, 3 default}
  localparam logic [39:0] VEC [NV] = '{
    {32'h0000_0000, 2'd2, 4'b0001, 2'd0},
    {32'h0000_0FFC, 2'd3, 4'b0001, 2'd0},
    {32'h0000_1000, 2'd2, 4'b0000, 2'd3},
    {32'h0000_4000, 2'd2, 4'b0010, 2'd1},
    {32'h0000_43FC, 2'd0, 4'b0010, 2'd1},
    {32'h0000_4400, 2'd0, 4'b0000, 2'd3},
    {32'h0001_0000, 2'd2, 4'b0100, 2'd2},
    {32'h0001_1FFC, 2'd3, 4'b0100, 2'd2},
    {32'h0001_2000, 2'd1, 4'b0000, 2'd3},
    {32'h8000_0000, 2'd2, 4'b1000, 2'd0},
    {32'h8000_0400, 2'd3, 4'b0000, 2'd3},
    {32'h7FFF_FFFC, 2'd2, 4'b0000, 2'd3},
    {32'h0000_3FFC, 2'd2, 4'b0000, 2'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] m_haddr = '0;
  logic [1:0]  m_htrans = '0;
  logic [DW-1:0] m_hrdata;
  logic m_hresp, m_hready, m_hexokay, s_hready;
  logic [NR-1:0] s_hsel;
  logic [NS*DW-1:0] s_hrdata;
  logic [NS-1:0] s_hresp = '0, s_hreadyout = '1, s_hexokay = 3'b101;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] sdata(int s);
    return 32'hC0DE_0000 | (32'h1111 * s);
  endfunction
  assign s_hrdata = {sdata(2), sdata(1), sdata(0)};

  ahb_lite_fabric dut_i (
    .clk(clk), .rst_n(rst_n), .m_haddr(m_haddr), .m_htrans(m_htrans),
    .m_hrdata(m_hrdata), .m_hresp(m_hresp), .m_hready(m_hready),
    .m_hexokay(m_hexokay), .s_hsel(s_hsel), .s_hready(s_hready),
    .s_hrdata(s_hrdata), .s_hresp(s_hresp), .s_hreadyout(s_hreadyout),
    .s_hexokay(s_hexokay)
  );

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", total, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int r = 0; r < NR; r++)
      chk(T_BASE[r][9:0] == 0 && T_SIZE[r][9:0] == 0 && T_SIZE[r] != 0,
          "R1 table alignment", {T_BASE[r], T_SIZE[r]}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(m_hready && !m_hresp, "R9 reset ready/resp", {m_hready, m_hresp}, 2'b10);
    chk(m_hrdata == 0 && !m_hexokay, "R9 reset data/xok", {m_hrdata, m_hexokay}, 0);

    for (int v = 0; v < NV; v++) begin
      logic [31:0] a;
      logic [1:0]  t, src;
      logic [3:0]  es;
      {a, t, es, src} = VEC[v];
      m_haddr = a; m_htrans = t;
      #1;
      chk(s_hsel == es, (es == 0) ? "R10 no select" : "R1/R2 region select", s_hsel, es);
      step();
      if (src == 3 && t[1]) begin
        m_htrans = 2'd0; m_haddr = 32'h0;
        #1;
        chk(m_hresp && !m_hready, "R5 error first cycle", {m_hresp, m_hready}, 2'b10);
        chk(s_hready == m_hready, "R7 ready broadcast", s_hready, m_hready);
        step();
        chk(m_hresp && m_hready, "R5 error second cycle", {m_hresp, m_hready}, 2'b11);
        chk(m_hrdata == 0, "R6 default rdata", m_hrdata, 0);
      end else if (src == 3) begin
        chk(!m_hresp && m_hready, "R6 idle/busy okay", {m_hresp, m_hready}, 2'b01);
        chk(m_hrdata == 0 && !m_hexokay, "R6/R8 default data", {m_hrdata, m_hexokay}, 0);
      end else begin
        chk(m_hrdata == sdata(int'(src)), "R3 data routed", m_hrdata, sdata(int'(src)));
        chk(!m_hresp && m_hready, "R3 response routed", {m_hresp, m_hready}, 2'b01);
        chk(m_hexokay == s_hexokay[src], "R8 exokay routed", m_hexokay, s_hexokay[src]);
      end
    end

    // R4: wait states hold the data-phase selection
    s_hreadyout[1] = 1'b0;
    m_haddr = 32'h0000_4000; m_htrans = 2'd2;
    step();
    m_haddr = 32'h0001_0000; m_htrans = 2'd2;
    #1;
    chk(!m_hready && !s_hready, "R7 wait broadcast", {m_hready, s_hready}, 2'b00);
    chk(m_hrdata == sdata(1), "R4 held slave data", m_hrdata, sdata(1));
    step();
    chk(m_hrdata == sdata(1) && !m_hready, "R4 still held", m_hrdata, sdata(1));
    s_hreadyout[1] = 1'b1;
    #1;
    chk(m_hready && s_hready, "R7 release broadcast", {m_hready, s_hready}, 2'b11);
    step();
    chk(m_hrdata == sdata(2), "R4 next slave after release", m_hrdata, sdata(2));
    s_hresp[2] = 1'b1; s_hreadyout[2] = 1'b0;
    #1;
    chk(m_hresp && !m_hready, "R3 slave error routed", {m_hresp, m_hready}, 2'b10);
    s_hresp[2] = 1'b0; s_hreadyout[2] = 1'b1;
    m_htrans = 2'd0;
    step();
    chk(!m_hresp && m_hready, "R3 slave okay routed", {m_hresp, m_hready}, 2'b01);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule